// File: doc/BRIEF.md
# Self Wake-up Countdown Timer

This block is a 32-bit down-counter that raises a sticky alarm, and with it an interrupt request, when a loaded interval has elapsed. Software controls it through two word registers on a small read/write bus. A control word at offset 0x0 selects the tick source and holds the alarm flag and a stop command. A count word at offset 0xC loads the start value and returns the live count when read.

The counter moves on one of three tick sources. Each source is a single-cycle enable in the system clock domain: a divided internal oscillator tick, a low-power oscillator tick, or an external tick. When the external bit is set it overrides the internal choice. Writing the count word starts a countdown. The stop command zeroes and freezes the counter until the next load. The alarm flag stays set until software writes a one to it.

Top module: `wake_timer`

## Requirements
- R1: After reset, reads of offset 0x0 and 0xC return 0 and irq_o is 0.
- R2: A write to offset 0xC loads the written value into the counter and starts counting. A read of 0xC returns the current count.
- R3: While running, the count drops by exactly one on each cycle in which the selected tick enable is 1. Without a selected tick it holds.
- R4: Tick source: control bit 3 = 1 selects tick_ext_i. With bit 3 = 0, control bit 0 = 0 selects tick_irc_i and bit 0 = 1 selects tick_lp_i. Ticks on unselected inputs have no effect.
- R5: When a tick takes the count from 1 to 0, control bit 1 (alarm) becomes 1 and counting stops: later ticks leave the count at 0.
- R6: A loaded value of 0 sets the alarm on the next selected tick, and the count stays 0 with no wrap.
- R7: Writing 1 to control bit 1 clears the alarm. Writing 0 to it leaves the alarm unchanged.
- R8: Writing 1 to control bit 2 sets the count to 0 and halts counting until a new load. Bit 2 always reads 0.
- R9: irq_o equals the alarm flag (control bit 1).
- R10: If a timeout and a write-one-to-clear of the alarm fall in the same cycle, the alarm stays 1.
- R11: A write to 0xC in the same cycle as a selected tick loads the written value with no decrement.
- R12: Reads of offsets 0x4 and 0x8 return 0, and writes to them change no register.
- R13: Changing the source bits while running keeps the current count, and the new source applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational on a read strobe |
| tick_irc_i | input | 1 | Divided internal oscillator tick enable |
| tick_lp_i | input | 1 | Low-power oscillator tick enable |
| tick_ext_i | input | 1 | External tick enable |
| irq_o | output | 1 | Interrupt request, follows the alarm flag |

## Verification
Two collisions can fall in one cycle. A final tick can meet a write-one-to-clear of the alarm, and a tick can meet a write to the count word. The bench provokes each by driving the bus write and the selected tick on the same falling edge. It then judges the outcome at the next falling edge: the alarm must still read 1 with irq_o high, or the count must equal the newly written value rather than that value less one.

// File: rtl/wake_timer_pkg.sv
package wake_timer_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'hC;

  // control word bit positions
  localparam int unsigned B_SRC_LP  = 0;
  localparam int unsigned B_ALARM   = 1;
  localparam int unsigned B_STOP    = 2;
  localparam int unsigned B_SRC_EXT = 3;

  typedef enum logic [1:0] {
    SRC_IRC = 2'd0,
    SRC_LP  = 2'd1,
    SRC_EXT = 2'd2
  } tick_src_e;
endpackage

// File: rtl/wkt_regif.sv
module wkt_regif
  import wake_timer_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic [DW-1:0] count_i,
  input  logic          alarm_i,
  output tick_src_e     src_o,
  output logic          load_o,
  output logic [DW-1:0] load_val_o,
  output logic          stop_o,
  output logic          alarm_clr_o
);
  logic sel_lp_q, sel_ext_q;
  logic hit_ctrl, hit_count, wr_ctrl;

  assign hit_ctrl  = (bus_addr_i == OFS_CTRL);
  assign hit_count = (bus_addr_i == OFS_COUNT);
  assign wr_ctrl   = bus_req_i && bus_we_i && hit_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_lp_q  <= 1'b0;
      sel_ext_q <= 1'b0;
    end else if (wr_ctrl) begin
      sel_lp_q  <= bus_wdata_i[B_SRC_LP];
      sel_ext_q <= bus_wdata_i[B_SRC_EXT];
    end
  end

  // external bit overrides internal choice
  always_comb begin
    if (sel_ext_q)     src_o = SRC_EXT;
    else if (sel_lp_q) src_o = SRC_LP;
    else               src_o = SRC_IRC;
  end

  assign load_o      = bus_req_i && bus_we_i && hit_count;
  assign load_val_o  = bus_wdata_i;
  assign stop_o      = wr_ctrl && bus_wdata_i[B_STOP];
  assign alarm_clr_o = wr_ctrl && bus_wdata_i[B_ALARM];

  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && !bus_we_i) begin
      if (hit_ctrl) begin
        bus_rdata_o[B_SRC_LP]  = sel_lp_q;
        bus_rdata_o[B_ALARM]   = alarm_i;
        bus_rdata_o[B_SRC_EXT] = sel_ext_q;
      end else if (hit_count) begin
        bus_rdata_o = count_i;
      end
    end
  end

  p_unmapped_read_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && !hit_ctrl && !hit_count) |-> (bus_rdata_o == '0));
  p_stop_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && hit_ctrl) |-> !bus_rdata_o[B_STOP]);
  p_unmapped_write_keeps_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && !hit_ctrl) |=> $stable(src_o));
endmodule

// File: rtl/wkt_tick_sel.sv
module wkt_tick_sel
  import wake_timer_pkg::*;
(
  input  tick_src_e src_i,
  input  logic      tick_irc_i,
  input  logic      tick_lp_i,
  input  logic      tick_ext_i,
  output logic      tick_o
);
  logic [2:0] ticks;
  assign ticks = {tick_ext_i, tick_lp_i, tick_irc_i};

  always_comb begin
    unique case (src_i)
      SRC_IRC: tick_o = ticks[0];
      SRC_LP:  tick_o = ticks[1];
      SRC_EXT: tick_o = ticks[2];
      default: tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          stop_i,
  input  logic          tick_i,
  input  logic          alarm_clr_i,
  output logic [DW-1:0] count_o,
  output logic          alarm_o
);
  logic [DW-1:0] count_q;
  logic          run_q, alarm_q;
  logic          step, expire;

  assign step   = run_q && tick_i && !load_i && !stop_i;
  assign expire = step && (count_q <= DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else if (load_i) begin
      count_q <= load_val_i;
      run_q   <= 1'b1;
    end else if (stop_i) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else if (step) begin
      if (count_q != '0) count_q <= count_q - DW'(1);
      if (expire)        run_q   <= 1'b0;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          alarm_q <= 1'b0;
    else if (expire)      alarm_q <= 1'b1;
    else if (alarm_clr_i) alarm_q <= 1'b0;
  end

  assign count_o = count_q;
  assign alarm_o = alarm_q;

  p_dec_by_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && !load_i && !stop_i && count_q != '0) |=> (count_q == $past(count_q) - DW'(1)));
  p_hold_no_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !stop_i) |=> $stable(count_q));
  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && !load_i) |=> (count_q == '0));
  p_load_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q == $past(load_val_i)));
  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> alarm_q);
  p_stop_halts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> (count_q == '0 && !run_q));
  p_alarm_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_q && !alarm_clr_i) |=> alarm_q);
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wake_timer_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          tick_irc_i,
  input  logic          tick_lp_i,
  input  logic          tick_ext_i,
  output logic          irq_o
);
  tick_src_e     src;
  logic          load, stop, alarm_clr, tick, alarm;
  logic [DW-1:0] load_val, count;

  wkt_regif #(.DW(DW), .AW(AW)) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .count_i     (count),
    .alarm_i     (alarm),
    .src_o       (src),
    .load_o      (load),
    .load_val_o  (load_val),
    .stop_o      (stop),
    .alarm_clr_o (alarm_clr)
  );

  wkt_tick_sel u_tick_sel (
    .src_i      (src),
    .tick_irc_i (tick_irc_i),
    .tick_lp_i  (tick_lp_i),
    .tick_ext_i (tick_ext_i),
    .tick_o     (tick)
  );

  wkt_counter #(.DW(DW)) u_counter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_val_i  (load_val),
    .stop_i      (stop),
    .tick_i      (tick),
    .alarm_clr_i (alarm_clr),
    .count_o     (count),
    .alarm_o     (alarm)
  );

  assign irq_o = alarm;
endmodule

// File: tb/wake_timer_test.sv
module wake_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        t_irc = 1'b0, t_lp = 1'b0, t_ext = 1'b0;
  logic        irq;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tick_irc_i(t_irc), .tick_lp_i(t_lp), .tick_ext_i(t_ext), .irq_o(irq)
  );

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  // 0 irc, 1 lp, 2 ext
  task automatic pulse(input int which);
    @(negedge clk);
    t_irc = (which == 0); t_lp = (which == 1); t_ext = (which == 2);
    @(negedge clk); t_irc = 0; t_lp = 0; t_ext = 0;
  endtask

  task automatic reset_dut();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reset_dut();
    rd(4'h0, d); check("R1 ctrl", d, 0);
    rd(4'hC, d); check("R1 count", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_load_count();
    logic [31:0] d;
    reset_dut();
    wr(4'hC, 32'd5);
    rd(4'hC, d); check("R2 load", d, 5);
    repeat (3) @(negedge clk);
    rd(4'hC, d); check("R3 hold without tick", d, 5);
    pulse(0); pulse(0);
    rd(4'hC, d); check("R3 two ticks", d, 3);
    pulse(1); pulse(2);
    rd(4'hC, d); check("R4 unselected ticks", d, 3);
  endtask

  task automatic t_sources();
    logic [31:0] d;
    reset_dut();
    wr(4'h0, 32'h1);
    wr(4'hC, 32'd10);
    pulse(0); pulse(2);
    rd(4'hC, d); check("R4 lp ignores irc/ext", d, 10);
    pulse(1);
    rd(4'hC, d); check("R4 lp tick", d, 9);
    wr(4'h0, 32'h9); // ext overrides bit 0
    pulse(1); pulse(0);
    rd(4'hC, d); check("R4 ext overrides", d, 9);
    pulse(2);
    rd(4'hC, d); check("R4 ext tick", d, 8);
  endtask

  task automatic t_timeout();
    logic [31:0] d;
    reset_dut();
    wr(4'hC, 32'd2);
    pulse(0);
    check("R5 not yet", {31'b0, irq}, 0);
    pulse(0);
    rd(4'h0, d); check("R5 alarm set", d, 32'h2);
    check("R9 irq high", {31'b0, irq}, 1);
    pulse(0); pulse(0);
    rd(4'hC, d); check("R5 stays zero", d, 0);
    wr(4'h0, 32'h0);
    check("R7 write 0 keeps", {31'b0, irq}, 1);
    wr(4'h0, 32'h2);
    rd(4'h0, d); check("R7 w1c", d, 0);
    check("R9 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_load_zero();
    logic [31:0] d;
    reset_dut();
    wr(4'hC, 32'd0);
    check("R6 no alarm before tick", {31'b0, irq}, 0);
    pulse(0);
    check("R6 alarm on tick", {31'b0, irq}, 1);
    rd(4'hC, d); check("R6 no wrap", d, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    reset_dut();
    wr(4'hC, 32'd7);
    wr(4'h0, 32'h4);
    rd(4'hC, d); check("R8 stop zeroes", d, 0);
    rd(4'h0, d); check("R8 bit2 reads 0", d, 0);
    pulse(0); pulse(0);
    check("R8 halted no alarm", {31'b0, irq}, 0);
    wr(4'hC, 32'd1);
    pulse(0);
    check("R8 restart after load", {31'b0, irq}, 1);
  endtask

  task automatic t_set_vs_clear();
    reset_dut();
    wr(4'hC, 32'd1);
    @(negedge clk); req = 1; we = 1; addr = 4'h0; wdata = 32'h2; t_irc = 1;
    @(negedge clk); req = 0; we = 0; t_irc = 0;
    check("R10 set wins", {31'b0, irq}, 1);
  endtask

  task automatic t_load_vs_tick();
    logic [31:0] d;
    reset_dut();
    wr(4'hC, 32'd5);
    @(negedge clk); req = 1; we = 1; addr = 4'hC; wdata = 32'd20; t_irc = 1;
    @(negedge clk); req = 0; we = 0; t_irc = 0;
    rd(4'hC, d); check("R11 load wins", d, 20);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    reset_dut();
    wr(4'hC, 32'h33);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h4, d); check("R12 read 0x4", d, 0);
    rd(4'h8, d); check("R12 read 0x8", d, 0);
    rd(4'h0, d); check("R12 ctrl untouched", d, 0);
    rd(4'hC, d); check("R12 count untouched", d, 32'h33);
  endtask

  task automatic t_switch();
    logic [31:0] d;
    reset_dut();
    wr(4'hC, 32'd10);
    pulse(0); pulse(0);
    wr(4'h0, 32'h8);
    rd(4'hC, d); check("R13 count kept", d, 8);
    pulse(0);
    rd(4'hC, d); check("R13 old source off", d, 8);
    pulse(2);
    rd(4'hC, d); check("R13 new source", d, 7);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load_count();
        t_sources();
        t_timeout();
        t_load_zero();
        t_stop();
        t_set_vs_clear();
        t_load_vs_tick();
        t_unmapped();
        t_switch();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule